// File: doc/BRIEF.md
# Regulator Rail Fault Supervisor

This block holds the latched fault response of one regulator rail. External comparators report overcurrent at two levels, overvoltage (relative to the DAC code and absolute) and undervoltage. Each overcurrent level has two threshold sets: one for the full-power state and one for the light-load states. The supervisor picks the set that matches the current power state. It runs a latch-off timer for the lower overcurrent level. It also drives three rail-level requests: shutdown, a PWM override and a request to drop the ready flag.

When the output goes over voltage, the supervisor drives PWM low and asks the DAC owner to ramp the reference down to zero. While the ramp runs, it lets PWM go back to mid level whenever the output is below the relative threshold again. Once the DAC code reaches zero, PWM stays low. During soft start the absolute threshold decides entry instead of the relative one, so that a pre-charged output does not cause a false trip.

Faults are cleared only by taking the enable low, which also covers a supply cycle through reset. Undervoltage drops the ready flag and nothing else.

Top module: `rail_fault_supervisor`

## Requirements
- R1: With the selected delayed-overcurrent flag sampled high on OC_DELAY consecutive rising edges, `shutdown_req` is high after the OC_DELAY-th edge and low before it.
- R2: The selected immediate-overcurrent flag sampled high on one rising edge sets `shutdown_req` after that edge.
- R3: When `pwr_state` is 0 (full power), only `oc_dly_full` and `oc_imm_full` count. For any other value (1, 2, 3), only `oc_dly_lite` and `oc_imm_lite` count. The unselected pair has no effect.
- R4: Every fault response is latched. It clears on the edge after `rail_en` is sampled low. While `rail_en` is low, all fault inputs are ignored and the outputs stay at their idle values: `shutdown_req`=0, `rdy_drop`=0, `dac_ramp_dn`=0, `pwm_mode`=0.
- R5: An overvoltage entry sets `pwm_mode` to 1 (force low), `rdy_drop` to 1 and `dac_ramp_dn` to 1 after the edge at which it is sampled.
- R6: During the ramp-down with a nonzero `dac_code`, `pwm_mode` becomes 2 (mid) after an edge with `ov_rel` low, and 1 after an edge with `ov_rel` high.
- R7: A `dac_code` of zero sampled during the ramp-down ends it: `dac_ramp_dn` goes to 0 and `pwm_mode` stays 1 until `rail_en` goes low, whatever `ov_rel` does.
- R8: While `in_softstart` is high, `ov_abs` decides overvoltage entry and `ov_rel` alone does not cause an entry.
- R9: A sampled `uv_flag` latches `rdy_drop` high. It leaves `shutdown_req` at 0 and `pwm_mode` at 0.
- R10: If the delayed flag drops before the timer expires, the timer restarts. OC_DELAY-1 high edges, a low edge, then OC_DELAY-1 more high edges do not trip.
- R11: When overvoltage and overcurrent are sampled on the same edge, only the overvoltage response is taken. Once one of the two responses is latched, the other is ignored.
- R12: After an overcurrent shutdown, `pwm_mode` is 2 (mid) and `rdy_drop` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (supply-level) |
| rail_en | input | 1 | Rail enable; low clears all latched faults |
| pwr_state | input | 2 | Power state, 0 = full power |
| oc_dly_full | input | 1 | Delayed-overcurrent flag, full-power threshold |
| oc_imm_full | input | 1 | Immediate-overcurrent flag, full-power threshold |
| oc_dly_lite | input | 1 | Delayed-overcurrent flag, light-load threshold |
| oc_imm_lite | input | 1 | Immediate-overcurrent flag, light-load threshold |
| ov_rel | input | 1 | Output above DAC plus overvoltage margin |
| ov_abs | input | 1 | Output above absolute soft-start threshold |
| in_softstart | input | 1 | Soft start in progress |
| uv_flag | input | 1 | Output below undervoltage threshold |
| dac_code | input | DAC_W | Current DAC code |
| shutdown_req | output | 1 | Latched rail shutdown request |
| pwm_mode | output | 2 | PWM override: 0 normal, 1 force low, 2 mid |
| rdy_drop | output | 1 | Request to deassert the ready flag |
| dac_ramp_dn | output | 1 | Command to the DAC owner to ramp down to zero |

## Verification
The bound checker watches, on every cycle, that latched shutdown persists while enabled and that enable-low clears everything. It also checks the one-edge immediate trip, the mid/low alternation while ramping, the low hold after the ramp ends, undervoltage raising the ready drop, and that the overvoltage ramp and shutdown never coexist. Some behaviours need whole scenarios and only the bench can show them: the exact latch-off timer length, the timer restart on a dropped flag, the threshold set chosen per power state, and the soft-start masking of the relative comparator.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
   typedef enum logic [1:0] {
      PWM_NORMAL = 2'd0,
      PWM_LOW    = 2'd1,
      PWM_MID    = 2'd2
   } pwm_cmd_e;

   typedef enum logic [1:0] {
      OVS_IDLE = 2'd0,
      OVS_RAMP = 2'd1,
      OVS_HOLD = 2'd2
   } ov_state_e;

   localparam logic [1:0] PS_FULL = 2'd0;
endpackage

// File: rtl/fsup_thr_sel.sv
module fsup_thr_sel (
   input  logic [1:0] pwr_state,
   input  logic       dly_full,
   input  logic       imm_full,
   input  logic       dly_lite,
   input  logic       imm_lite,
   output logic       dly_sel,
   output logic       imm_sel
);
   import fsup_pkg::*;
   logic full_pwr;
   assign full_pwr = (pwr_state == PS_FULL);
   always_comb begin
      if (full_pwr) begin
         dly_sel = dly_full;
         imm_sel = imm_full;
      end else begin
         dly_sel = dly_lite;
         imm_sel = imm_lite;
      end
   end
endmodule

// File: rtl/fsup_oc_timer.sv
module fsup_oc_timer #(
   parameter int OC_DELAY = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic blk,
   input  logic dly,
   input  logic imm,
   output logic trip
);
   localparam int CNT_W = (OC_DELAY > 2) ? $clog2(OC_DELAY) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OC_DELAY - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             trip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         trip_q <= 1'b0;
      end else if (clr) begin
         cnt_q  <= '0;
         trip_q <= 1'b0;
      end else if (!trip_q) begin
         if (blk) begin
            cnt_q <= '0;
         end else if (imm) begin
            trip_q <= 1'b1;
         end else if (dly) begin
            if (cnt_q == LAST) trip_q <= 1'b1;
            else               cnt_q  <= cnt_q + 1'b1;
         end else begin
            cnt_q <= '0;
         end
      end
   end

   assign trip = trip_q;
endmodule

// File: rtl/fsup_ov_seq.sv
module fsup_ov_seq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       blk,
   input  logic       hit,
   input  logic       above,
   input  logic       dac_zero,
   output logic       active,
   output logic       ramp,
   output logic [1:0] pwm
);
   import fsup_pkg::*;
   ov_state_e st_q;
   pwm_cmd_e  pwm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= OVS_IDLE;
         pwm_q <= PWM_NORMAL;
      end else if (clr) begin
         st_q  <= OVS_IDLE;
         pwm_q <= PWM_NORMAL;
      end else begin
         case (st_q)
            OVS_IDLE: if (hit && !blk) begin
               st_q  <= OVS_RAMP;
               pwm_q <= PWM_LOW;
            end
            OVS_RAMP: if (dac_zero) begin
               st_q  <= OVS_HOLD;
               pwm_q <= PWM_LOW;
            end else begin
               pwm_q <= above ? PWM_LOW : PWM_MID;
            end
            OVS_HOLD: pwm_q <= PWM_LOW;
            default: begin
               st_q  <= OVS_IDLE;
               pwm_q <= PWM_NORMAL;
            end
         endcase
      end
   end

   assign active = (st_q != OVS_IDLE);
   assign ramp   = (st_q == OVS_RAMP);
   assign pwm    = pwm_q;
endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor #(
   parameter int DAC_W           = 8,
   parameter int OC_DELAY        = 50,
   parameter bit OV_ABS_AT_START = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rail_en,
   input  logic [1:0]       pwr_state,
   input  logic             oc_dly_full,
   input  logic             oc_imm_full,
   input  logic             oc_dly_lite,
   input  logic             oc_imm_lite,
   input  logic             ov_rel,
   input  logic             ov_abs,
   input  logic             in_softstart,
   input  logic             uv_flag,
   input  logic [DAC_W-1:0] dac_code,
   output logic             shutdown_req,
   output logic [1:0]       pwm_mode,
   output logic             rdy_drop,
   output logic             dac_ramp_dn
);
   import fsup_pkg::*;

   generate
      if (DAC_W < 1 || DAC_W > 16) begin : g_bad_dac_w
         $error("rail_fault_supervisor: DAC_W out of range");
      end
      if (OC_DELAY < 2) begin : g_bad_delay
         $error("rail_fault_supervisor: OC_DELAY must be at least 2");
      end
   endgenerate

   logic clr;
   logic dly_sel, imm_sel;
   logic ov_hit;
   logic oc_trip;
   logic ov_active, ov_ramp;
   logic [1:0] ov_pwm;
   logic uv_q;
   logic dac_zero;

   assign clr      = !rail_en;
   assign dac_zero = (dac_code == '0);

   generate
      if (OV_ABS_AT_START) begin : g_ov_abs
         assign ov_hit = in_softstart ? ov_abs : ov_rel;
      end else begin : g_ov_rel
         assign ov_hit = ov_rel;
      end
   endgenerate

   fsup_thr_sel u_sel (
      .pwr_state (pwr_state),
      .dly_full  (oc_dly_full),
      .imm_full  (oc_imm_full),
      .dly_lite  (oc_dly_lite),
      .imm_lite  (oc_imm_lite),
      .dly_sel   (dly_sel),
      .imm_sel   (imm_sel)
   );

   fsup_oc_timer #(.OC_DELAY(OC_DELAY)) u_oc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .blk   (ov_active | ov_hit),
      .dly   (dly_sel),
      .imm   (imm_sel),
      .trip  (oc_trip)
   );

   fsup_ov_seq u_ov (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .blk      (oc_trip),
      .hit      (ov_hit),
      .above    (ov_rel),
      .dac_zero (dac_zero),
      .active   (ov_active),
      .ramp     (ov_ramp),
      .pwm      (ov_pwm)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      uv_q <= 1'b0;
      else if (clr)    uv_q <= 1'b0;
      else if (uv_flag) uv_q <= 1'b1;
   end

   assign shutdown_req = oc_trip;
   assign pwm_mode     = oc_trip ? PWM_MID : ov_pwm;
   assign rdy_drop     = oc_trip | ov_active | uv_q;
   assign dac_ramp_dn  = ov_ramp;
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
   parameter int DAC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rail_en,
   input logic [1:0]       pwr_state,
   input logic             oc_imm_full,
   input logic             ov_rel,
   input logic             ov_abs,
   input logic             in_softstart,
   input logic             uv_flag,
   input logic [DAC_W-1:0] dac_code,
   input logic             shutdown_req,
   input logic [1:0]       pwm_mode,
   input logic             rdy_drop,
   input logic             dac_ramp_dn
);
   assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rail_en && shutdown_req) |=> shutdown_req);

   assert_en_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rail_en |=> (!shutdown_req && !rdy_drop && !dac_ramp_dn && pwm_mode == 2'd0));

   assert_imm_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rail_en && !rdy_drop && pwr_state == 2'd0 && oc_imm_full && !ov_rel && !ov_abs)
      |=> shutdown_req);

   assert_ramp_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rail_en && dac_ramp_dn && !ov_rel && dac_code != '0) |=> pwm_mode == 2'd2);

   assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rail_en && pwm_mode == 2'd1 && !dac_ramp_dn) |=> (pwm_mode == 2'd1 && !dac_ramp_dn));

   assert_uv_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rail_en && uv_flag) |=> rdy_drop);

   assert_ov_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(dac_ramp_dn && shutdown_req));

   assert_pwm_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_mode != 2'd3);

   logic unused_ok;
   assign unused_ok = in_softstart;
endmodule

bind rail_fault_supervisor fsup_checker #(.DAC_W(DAC_W)) u_fsup_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rail_en      (rail_en),
   .pwr_state    (pwr_state),
   .oc_imm_full  (oc_imm_full),
   .ov_rel       (ov_rel),
   .ov_abs       (ov_abs),
   .in_softstart (in_softstart),
   .uv_flag      (uv_flag),
   .dac_code     (dac_code),
   .shutdown_req (shutdown_req),
   .pwm_mode     (pwm_mode),
   .rdy_drop     (rdy_drop),
   .dac_ramp_dn  (dac_ramp_dn)
);

// File: tb/tb_rail_fault_supervisor.sv
module tb_rail_fault_supervisor;
   localparam int DW = 8;
   localparam int ND = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rail_en = 1'b0;
   logic [1:0] pwr_state = 2'd0;
   logic oc_dly_full = 0, oc_imm_full = 0, oc_dly_lite = 0, oc_imm_lite = 0;
   logic ov_rel = 0, ov_abs = 0, in_softstart = 0, uv_flag = 0;
   logic [DW-1:0] dac_code = 8'd100;
   logic shutdown_req, rdy_drop, dac_ramp_dn;
   logic [1:0] pwm_mode;
   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   rail_fault_supervisor #(.DAC_W(DW), .OC_DELAY(ND), .OV_ABS_AT_START(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .pwr_state(pwr_state),
      .oc_dly_full(oc_dly_full), .oc_imm_full(oc_imm_full),
      .oc_dly_lite(oc_dly_lite), .oc_imm_lite(oc_imm_lite),
      .ov_rel(ov_rel), .ov_abs(ov_abs), .in_softstart(in_softstart),
      .uv_flag(uv_flag), .dac_code(dac_code),
      .shutdown_req(shutdown_req), .pwm_mode(pwm_mode),
      .rdy_drop(rdy_drop), .dac_ramp_dn(dac_ramp_dn)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic sd, input logic [1:0] pm,
                      input logic rd, input logic dn);
      total++;
      if (shutdown_req !== sd || pwm_mode !== pm || rdy_drop !== rd || dac_ramp_dn !== dn) begin
         bad++;
         $display("FAIL %s: got sd=%b pwm=%0d rdy=%b dn=%b exp sd=%b pwm=%0d rdy=%b dn=%b",
                  req, shutdown_req, pwm_mode, rdy_drop, dac_ramp_dn, sd, pm, rd, dn);
      end
   endtask

   task automatic quiet_clear();
      oc_dly_full = 0; oc_imm_full = 0; oc_dly_lite = 0; oc_imm_lite = 0;
      ov_rel = 0; ov_abs = 0; in_softstart = 0; uv_flag = 0;
      pwr_state = 2'd0; dac_code = 8'd100;
      rail_en = 0; tick(1); rail_en = 1; tick(1);
   endtask

   task automatic t_reset();
      chk("R4 reset idle", 0, 2'd0, 0, 0);
   endtask

   task automatic t_delayed_oc();
      quiet_clear();
      oc_dly_full = 1;
      tick(ND - 1);
      chk("R1 before expiry", 0, 2'd0, 0, 0);
      tick(1);
      chk("R1 at expiry R12", 1, 2'd2, 1, 0);
      oc_dly_full = 0;
      tick(3);
      chk("R4 latched after flag clears", 1, 2'd2, 1, 0);
      rail_en = 0; tick(1);
      chk("R4 enable low clears", 0, 2'd0, 0, 0);
      oc_imm_full = 1; uv_flag = 1; ov_rel = 1; tick(2);
      chk("R4 inputs ignored while disabled", 0, 2'd0, 0, 0);
      oc_imm_full = 0; uv_flag = 0; ov_rel = 0; rail_en = 1; tick(1);
   endtask

   task automatic t_timer_restart();
      quiet_clear();
      oc_dly_full = 1; tick(ND - 1);
      oc_dly_full = 0; tick(1);
      oc_dly_full = 1; tick(ND - 1);
      chk("R10 restart no trip", 0, 2'd0, 0, 0);
      tick(1);
      chk("R10 trip after full run", 1, 2'd2, 1, 0);
   endtask

   task automatic t_power_state();
      quiet_clear();
      pwr_state = 2'd2;
      oc_dly_full = 1; oc_imm_full = 1; tick(ND + 3);
      chk("R3 full set ignored in light state", 0, 2'd0, 0, 0);
      oc_dly_full = 0; oc_imm_full = 0;
      oc_imm_lite = 1; tick(1);
      chk("R3 light imm trips R2", 1, 2'd2, 1, 0);
      quiet_clear();
      pwr_state = 2'd0;
      oc_dly_lite = 1; oc_imm_lite = 1; tick(ND + 3);
      chk("R3 light set ignored in full state", 0, 2'd0, 0, 0);
      oc_dly_lite = 0; oc_imm_lite = 0;
      oc_imm_full = 1; tick(1);
      chk("R2 full imm trips in one edge", 1, 2'd2, 1, 0);
      quiet_clear();
      pwr_state = 2'd3; oc_dly_lite = 1; tick(ND);
      chk("R1 light delayed trips", 1, 2'd2, 1, 0);
   endtask

   task automatic t_overvoltage();
      quiet_clear();
      ov_rel = 1; tick(1);
      chk("R5 ov entry", 0, 2'd1, 1, 1);
      ov_rel = 0; tick(1);
      chk("R6 below margin mid", 0, 2'd2, 1, 1);
      ov_rel = 1; tick(1);
      chk("R6 above margin low", 0, 2'd1, 1, 1);
      oc_imm_full = 1; ov_rel = 0; tick(2);
      chk("R11 oc ignored during ov", 0, 2'd2, 1, 1);
      oc_imm_full = 0;
      dac_code = 8'd0; tick(1);
      chk("R7 ramp done hold low", 0, 2'd1, 1, 0);
      ov_rel = 0; dac_code = 8'd50; tick(3);
      chk("R7 low held", 0, 2'd1, 1, 0);
      rail_en = 0; tick(1);
      chk("R4 ov cleared by enable", 0, 2'd0, 0, 0);
      rail_en = 1; tick(1);
   endtask

   task automatic t_softstart();
      quiet_clear();
      in_softstart = 1; ov_rel = 1; tick(3);
      chk("R8 relative masked in soft start", 0, 2'd0, 0, 0);
      ov_abs = 1; tick(1);
      chk("R8 absolute trips", 0, 2'd1, 1, 1);
   endtask

   task automatic t_priority();
      quiet_clear();
      ov_rel = 1; oc_imm_full = 1; tick(1);
      chk("R11 same-cycle ov wins", 0, 2'd1, 1, 1);
      quiet_clear();
      oc_imm_full = 1; tick(1);
      oc_imm_full = 0; ov_rel = 1; tick(2);
      chk("R11 ov ignored after oc", 1, 2'd2, 1, 0);
   endtask

   task automatic t_uv();
      quiet_clear();
      uv_flag = 1; tick(1);
      uv_flag = 0; tick(2);
      chk("R9 uv drops ready only", 0, 2'd0, 1, 0);
   endtask

   initial begin
      tick(2);
      t_reset();
      rst_n = 1; rail_en = 1;
      tick(1);
      chk("R4 idle after reset", 0, 2'd0, 0, 0);
      t_delayed_oc();
      t_timer_restart();
      t_power_state();
      t_overvoltage();
      t_softstart();
      t_priority();
      t_uv();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got running exp finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule